// File: doc/BRIEF.md
# Page-Load Buffer and Write Timer

This block is the write path of a byte-wide, page-organised nonvolatile memory model. A host issues byte-load strobes through an active-low chip select and an active-low write enable, with the output enable held inactive. Each accepted strobe places one data byte into a 128-entry page buffer. The low seven address bits choose the slot in that buffer. The upper ten bits choose the page, and the page of the most recent accepted byte is the one that is written. Loading the same slot again replaces the earlier value.

Once the first byte is accepted, the block stays in its load phase for as long as each new strobe begins within a programmable number of idle cycles after the previous one ended. When that idle limit runs out, an internally timed commit cycle starts and cannot be stopped. In its first 128 cycles the commit cycle drives every slot of the page, in ascending order, onto a one-byte-per-cycle array write port. A slot that was never loaded is sent as FFH. The commit cycle then runs out its full programmed length, and all buffer slots return to the empty state. A busy flag covers both the load phase and the commit cycle. Strobes that begin during the commit cycle are dropped.

The control inputs are sampled on the clock. A strobe counts only while chip select and write enable are both low and output enable is high. It must also stay active for a minimum number of sampled cycles, so shorter pulses are rejected as glitches. The address is taken in the first active cycle and the data in the last active cycle.

Top module: `page_load_writer`

## Requirements
- R1: During and directly after reset, busy and arr_we are low.
- R2: A strobe is the run of sampled cycles with cs_n=0, we_n=0 and oe_n=1. A strobe of at least MIN_PULSE cycles is accepted. It stores the din value from its last active cycle into the slot given by bits [6:0] of the addr value from its first active cycle.
- R3: A strobe shorter than MIN_PULSE cycles stores nothing and does not start a load phase.
- R4: With oe_n low or cs_n high, a low we_n stores nothing and does not start a load phase.
- R5: busy rises on the first clock edge that ends an accepted strobe. It stays high through the load phase and the commit cycle.
- R6: The commit cycle starts on the LOAD_TIMEOUT-th clock edge after the edge that ended the last strobe, provided no strobe is active in that span. A strobe that becomes active on or before the next edge keeps the load phase open.
- R7: An accepted strobe to a slot that already holds data replaces that data.
- R8: All bytes of a commit go to the page given by addr[16:7] of the last accepted strobe.
- R9: A slot not loaded since the previous commit is written as FFH.
- R10: The commit cycle drives arr_we high for exactly 128 consecutive cycles, with arr_addr[6:0] running from 0 to 127. busy falls WRITE_CYCLES clock edges after the commit cycle began.
- R11: A strobe that becomes active during the commit cycle changes neither the buffer nor the page, and it does not start a new load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; a low level inhibits loading |
| addr | input | 17 | Byte address: page in [16:7], slot in [6:0] |
| din | input | 8 | Byte to load |
| busy | output | 1 | High during the load phase and the commit cycle |
| arr_we | output | 1 | Array write strobe, one byte per cycle |
| arr_addr | output | 17 | Array write address |
| arr_data | output | 8 | Array write data |

## Verification
The edge that ends a strobe is counted as edge one after the host releases the strobe. busy must be high at the falling clock edge that follows it. arr_we must still be low after LOAD_TIMEOUT edges and high one edge later. The 128 array writes are then compared one per falling edge against a bench model of slot contents, fill flags and page. busy is checked high WRITE_CYCLES-1 edges after the first array write and low one edge after that. Every check samples on the falling clock edge, exactly at these counted positions. Idle gaps, including a gap of exactly LOAD_TIMEOUT cycles, are placed so that each commit's start cycle is known in advance.

// File: rtl/page_load_writer.sv
module page_load_writer #(
  parameter int ADDR_W       = 17,
  parameter int OFS_W        = 7,
  parameter int DATA_W       = 8,
  parameter int LOAD_TIMEOUT = 50000,
  parameter int WRITE_CYCLES = 1250000,
  parameter int MIN_PULSE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int TMR_W      = $clog2(LOAD_TIMEOUT + 1);
  localparam int WCNT_W     = $clog2(WRITE_CYCLES + 1);
  localparam int PL_W       = $clog2(MIN_PULSE + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WRITE} st_t;

  st_t               state;
  logic              act, act_q, armed, commit;
  logic [PL_W-1:0]   plen;
  logic [ADDR_W-1:0] addr_lat;
  logic [DATA_W-1:0] data_lat;
  logic [PAGE_W-1:0] page_q;
  logic [TMR_W-1:0]  tmr;
  logic [WCNT_W-1:0] wcnt;
  logic [PAGE_BYTES-1:0] filled;
  logic [DATA_W-1:0] page_buf [PAGE_BYTES];
  logic [OFS_W-1:0]  rd_ofs;

  assign act    = ~cs_n & ~we_n & oe_n;
  assign commit = act_q & ~act & armed & (plen >= PL_W'(MIN_PULSE)) & (state != ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      armed    <= 1'b0;
      plen     <= '0;
      addr_lat <= '0;
      data_lat <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) begin
        plen     <= PL_W'(1);
        addr_lat <= addr;
        armed    <= (state != ST_WRITE);
      end else if (act && plen < PL_W'(MIN_PULSE)) begin
        plen <= plen + PL_W'(1);
      end
      if (act) data_lat <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) page_buf[addr_lat[OFS_W-1:0]] <= data_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      page_q <= '0;
      tmr    <= '0;
      wcnt   <= '0;
      filled <= '0;
    end else begin
      if (commit) begin
        filled[addr_lat[OFS_W-1:0]] <= 1'b1;
        page_q <= addr_lat[ADDR_W-1:OFS_W];
      end
      case (state)
        ST_IDLE: begin
          tmr <= '0;
          if (commit) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (commit || act) begin
            tmr <= '0;
          end else if (tmr == TMR_W'(LOAD_TIMEOUT - 1)) begin
            state <= ST_WRITE;
            wcnt  <= '0;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_WRITE: begin
          if (wcnt == WCNT_W'(WRITE_CYCLES - 1)) begin
            state  <= ST_IDLE;
            filled <= '0;
          end else begin
            wcnt <= wcnt + WCNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_ofs   = wcnt[OFS_W-1:0];
  assign busy     = (state != ST_IDLE);
  assign arr_we   = (state == ST_WRITE) && (wcnt < WCNT_W'(PAGE_BYTES));
  assign arr_addr = {page_q, rd_ofs};
  assign arr_data = filled[rd_ofs] ? page_buf[rd_ofs] : {DATA_W{1'b1}};

  assert_short_pulse_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && act_q && !act && plen < PL_W'(MIN_PULSE)) |=> !busy);

  assert_busy_ends_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(state) == ST_WRITE);

  assert_load_held_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && act) |=> state == ST_LOAD);

  assert_first_slot_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_we) |-> arr_addr[OFS_W-1:0] == '0);

  assert_slot_ascends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> arr_addr[OFS_W-1:0] == OFS_W'($past(arr_addr[OFS_W-1:0]) + 1'b1));

  assert_page_frozen_in_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE) |=> $stable(page_q));
endmodule

// File: tb/test_page_load_writer.sv
`timescale 1ns/1ps
module test_page_load_writer;
  localparam int T  = 40;
  localparam int W  = 200;
  localparam int MP = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic        busy, arr_we;
  logic [16:0] arr_addr;
  logic [7:0]  arr_data;

  page_load_writer #(.LOAD_TIMEOUT(T), .WRITE_CYCLES(W), .MIN_PULSE(MP)) i_page_load_writer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_buf [128];
  bit         exp_fill [128];
  logic [9:0] exp_page;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int ofs);
    return exp_fill[ofs] ? exp_buf[ofs] : 8'hFF;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 128; i++) exp_fill[i] = 1'b0;
  endtask

  task automatic release_bus();
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = 17'($urandom); din = 8'($urandom);
  endtask

  task automatic strobe(input logic [16:0] a, input logic [7:0] d, input int len,
                        input bit oe_lo, input bit cs_hi);
    addr = a; din = d; cs_n = cs_hi; we_n = 1'b0; oe_n = ~oe_lo ? 1'b1 : 1'b0;
    repeat (len) @(negedge clk);
    release_bus();
  endtask

  task automatic load(input logic [16:0] a, input logic [7:0] d, input int len);
    strobe(a, d, len, 1'b0, 1'b0);
    exp_buf[a[6:0]] = d; exp_fill[a[6:0]] = 1'b1; exp_page = a[16:7];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_write(input string tag);
    idle(T);
    chk("R6 no commit before timeout", arr_we, 0);
    chk("R5 busy in load phase", busy, 1);
    idle(1);
    for (int k = 0; k < 128; k++) begin
      chk("R10 arr_we during commit", arr_we, 1);
      chk({tag, " R8 address"}, arr_addr, {exp_page, 7'(k)});
      chk({tag, " R9 R2 data"}, arr_data, exp_byte(k));
      if (k == 3) begin
        addr = {exp_page, 7'h7F}; din = 8'h5A; cs_n = 1'b0; we_n = 1'b0;
      end
      if (k == 6) release_bus();
      idle(1);
    end
    chk("R10 arr_we drops after 128", arr_we, 0);
    idle(W - 129);
    chk("R10 busy held to end", busy, 1);
    idle(1);
    chk("R10 busy falls", busy, 0);
    clear_model();
    idle(5);
    chk("R11 strobe in commit ignored", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    clear_model();
    idle(3);
    chk("R1 busy in reset", busy, 0);
    chk("R1 arr_we in reset", arr_we, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 busy after reset", busy, 0);

    strobe(17'h00A05, 8'h11, 3, 1'b1, 1'b0);
    idle(T + 5);
    chk("R4 oe_n low inhibits", busy, 0);
    strobe(17'h00A05, 8'h12, 3, 1'b0, 1'b1);
    idle(T + 5);
    chk("R4 cs_n high inhibits", busy, 0);
    strobe(17'h00A05, 8'h13, MP - 1, 1'b0, 1'b0);
    idle(1);
    chk("R3 short pulse no load", busy, 0);
    idle(T + 5);
    chk("R3 short pulse no commit", busy, 0);

    // directed page: latch timing, overwrite, glitch, exact-timeout gap, page switch
    addr = 17'h1A2B3; din = 8'h11; cs_n = 1'b0; we_n = 1'b0;
    idle(1); addr = 17'h00077; din = 8'h22;
    idle(1); din = 8'h33;
    idle(1); release_bus();
    exp_buf[7'h33] = 8'h33; exp_fill[7'h33] = 1'b1; exp_page = 10'h345;
    idle(1);
    chk("R5 busy after first load", busy, 1);
    idle(4);
    load(17'h1A2B3, 8'h44, 3);
    idle(3);
    strobe(17'h1A285, 8'h99, MP - 1, 1'b0, 1'b0);
    idle(3);
    load(17'h1A2FF, 8'hE7, 2);
    idle(T);
    chk("R6 still loading at gap limit", busy, 1);
    load(17'h1A280, 8'h01, 2);
    idle(2);
    load({10'h2C1, 7'd9}, 8'hC3, 4);
    run_write("R7");

    for (int r = 0; r < 7; r++) begin
      int nb;
      logic [9:0] pg;
      nb = (r == 6) ? 128 : 1 + int'($urandom % 48);
      pg = 10'($urandom);
      idle(1 + int'($urandom % 4));
      for (int b = 0; b < nb; b++) begin
        logic [6:0] ofs;
        if ($urandom % 8 == 0) pg = 10'($urandom);
        ofs = (r == 6) ? 7'(b) : 7'($urandom);
        load({pg, ofs}, 8'($urandom), MP + int'($urandom % 3));
        if (b != nb - 1) idle(1 + int'($urandom % T));
      end
      run_write("R2 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule